// File: doc/BRIEF.md
# Overcurrent Shutdown Latch with Self-Held Pull-Down

This block is the digital decision core of a fast overcurrent protection scheme for a bank of half-bridges. A comparator trip input removes every gate enable on the next clock edge, taking a short path that does not wait for the shared shutdown line to discharge. In the same cycle the block switches on an open-drain pull-down on that line, so that other parties sharing the line see the fault.

The pull-down is not held for a fixed time. It stays on until the synchronized level of the line reads low and the trip has cleared. After that the external resistor and capacitor recharge the line, and the gates stay off until the line reads high again. The recharge time therefore lengthens the total disable time, while the delay from trip to gate turn-off stays fixed. A sticky fault flag records every trip until it is cleared by a one-cycle clear pulse.

Top module: `smart_sd_latch`

## Requirements
- R1: After reset the pull-down enable is 0, the fault flag is 0 and every gate output is 0. The gates stay 0 until the synchronized line level reads 1.
- R2: When the trip input is 1 at a clock edge, every high-side and low-side gate output is 0 after that edge, whatever the line level.
- R3: When the trip input is 1 at a clock edge, the pull-down enable and the fault flag are both 1 after that edge.
- R4: Once on, the pull-down enable stays 1 while the synchronized line reads 1. It also stays 1 while the trip input is 1.
- R5: The pull-down enable turns off at the first edge where the synchronized line reads 0 and the trip input is 0.
- R6: After a trip, the gates stay 0 while the pull-down is on and while the line recharges. They are re-enabled at the first edge where the pull-down is off, the trip is 0 and the synchronized line reads 1.
- R7: The raw line level passes through SYNC_STAGES flip-flops before any decision uses it.
- R8: If the synchronized line reads 0 during normal running, the gates go to 0 and the pull-down enable stays 0.
- R9: The fault flag stays 1 until a clear pulse arrives with the trip input at 0. A clear pulse in the same cycle as a trip leaves the flag set.
- R10: During normal running with no trip and the line high, each gate output equals its request from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_i | input | 1 | Overcurrent comparator trip, active high, not filtered |
| sd_pin_i | input | 1 | Digitized level of the shared shutdown line (1 = above the upper threshold) |
| fault_clr_i | input | 1 | One-cycle pulse that clears the fault flag |
| hi_req_i | input | LEGS | High-side gate requests from the controller, one bit per leg |
| lo_req_i | input | LEGS | Low-side gate requests from the controller, one bit per leg |
| hi_gate_o | output | LEGS | High-side gate enables, registered |
| lo_gate_o | output | LEGS | Low-side gate enables, registered |
| od_en_o | output | 1 | Enable for the open-drain pull-down on the shutdown line |
| fault_o | output | 1 | Sticky fault flag |

## Verification
The bench targets several corner cases:
- A trip while the line still reads high. A design that waited for the line would keep driving the gates for the whole synchronizer delay.
- A trip that is still asserted after the line has fallen. A design that released the pull-down early would let the line recharge into a live fault.
- The instant just after the pull-down releases, while the line is still low. A design that re-enabled on release alone would switch the gates on too early.
- A clear pulse that coincides with a trip. A design where clear wins would lose a fault.
- An external low on the line during running. A design that treated this as a trip would wrongly assert the pull-down.

Random request, trip and line traffic is compared cycle by cycle against a reference model in the bench.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,  // gates follow requests
    ST_HOLD = 2'd1,  // pull-down on, waiting for line low and trip clear
    ST_WAIT = 2'd2   // pull-down off, waiting for line to recharge high
  } sdl_state_e;
endpackage

// File: rtl/sdl_pin_sync.sv
module sdl_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] pipe;

  // Reset value 0: the line counts as low until it has been sampled high.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= 1'b0;
          else     pipe[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b0;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign pin_o = pipe[STAGES-1];
endmodule

// File: rtl/sdl_fsm.sv
module sdl_fsm
  import sdl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic pin_s_i,
  input  logic fault_clr_i,
  output logic run_next_o,
  output logic od_en_o,
  output logic fault_o
);
  sdl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (trip_i)        state_d = ST_HOLD;
        else if (!pin_s_i) state_d = ST_WAIT;
      end
      ST_HOLD: begin
        if (!trip_i && !pin_s_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (trip_i)       state_d = ST_HOLD;
        else if (pin_s_i) state_d = ST_RUN;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  assign run_next_o = (state_d == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      od_en_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      od_en_o <= (state_d == ST_HOLD);
      fault_o <= trip_i | (fault_o & ~fault_clr_i);
    end
  end

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (od_en_o && !trip_i && !pin_s_i) |=> !od_en_o);
endmodule

// File: rtl/sdl_gate_mask.sv
module sdl_gate_mask #(
  parameter int LEGS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [LEGS-1:0] hi_req_i,
  input  logic [LEGS-1:0] lo_req_i,
  output logic [LEGS-1:0] hi_gate_o,
  output logic [LEGS-1:0] lo_gate_o
);
  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_gate_o[g] <= 1'b0;
          lo_gate_o[g] <= 1'b0;
        end else begin
          hi_gate_o[g] <= run_i & hi_req_i[g];
          lo_gate_o[g] <= run_i & lo_req_i[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/smart_sd_latch.sv
module smart_sd_latch #(
  parameter int LEGS        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trip_i,
  input  logic            sd_pin_i,
  input  logic            fault_clr_i,
  input  logic [LEGS-1:0] hi_req_i,
  input  logic [LEGS-1:0] lo_req_i,
  output logic [LEGS-1:0] hi_gate_o,
  output logic [LEGS-1:0] lo_gate_o,
  output logic            od_en_o,
  output logic            fault_o
);
  logic pin_s;
  logic run_next;

  sdl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(sd_pin_i), .pin_o(pin_s)
  );

  sdl_fsm u_fsm (
    .clk(clk), .rst(rst), .trip_i(trip_i), .pin_s_i(pin_s),
    .fault_clr_i(fault_clr_i), .run_next_o(run_next),
    .od_en_o(od_en_o), .fault_o(fault_o)
  );

  sdl_gate_mask #(.LEGS(LEGS)) u_gates (
    .clk(clk), .rst(rst), .run_i(run_next),
    .hi_req_i(hi_req_i), .lo_req_i(lo_req_i),
    .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o)
  );

  // R2
  trip_kills_gates_chk: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (hi_gate_o == '0 && lo_gate_o == '0));

  // R3
  trip_sets_od_chk: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (od_en_o && fault_o));

  // R4
  od_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (od_en_o && (trip_i || pin_s)) |=> od_en_o);

  // R6
  no_gate_under_od_chk: assert property (@(posedge clk) disable iff (rst)
    od_en_o |-> (hi_gate_o == '0 && lo_gate_o == '0));

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !fault_clr_i) |=> fault_o);
endmodule

// File: tb/smart_sd_latch_test.sv
`timescale 1ns/1ps
module smart_sd_latch_test;
  localparam int LEGS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 1'b0, pin = 1'b0, clr = 1'b0;
  logic [LEGS-1:0] hreq = '0, lreq = '0;
  logic [LEGS-1:0] hgate, lgate;
  logic od, flt;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model: 0 run, 1 hold, 2 wait
  int m_st = 2;
  logic [1:0] m_sync = 2'b00;
  logic [LEGS-1:0] e_h = '0, e_l = '0;
  logic e_od = 0, e_f = 0;

  always #2.5 clk = ~clk;

  smart_sd_latch #(.LEGS(LEGS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .trip_i(trip), .sd_pin_i(pin), .fault_clr_i(clr),
    .hi_req_i(hreq), .lo_req_i(lreq), .hi_gate_o(hgate), .lo_gate_o(lgate),
    .od_en_o(od), .fault_o(flt)
  );

  function automatic int next_state(int s, logic t, logic ps);
    if (s == 0) return t ? 1 : (!ps ? 2 : 0);
    if (s == 1) return (!t && !ps) ? 2 : 1;
    return t ? 1 : (ps ? 0 : 2);
  endfunction

  task automatic chk(string tag, string what, logic [LEGS-1:0] act, logic [LEGS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // one clock: inputs already driven; update model, take edge, compare
  task automatic step(string tag);
    int ns;
    if (rst) begin
      m_st = 2; m_sync = 2'b00; e_h = '0; e_l = '0; e_od = 0; e_f = 0;
    end else begin
      ns = next_state(m_st, trip, m_sync[1]);
      e_h = (ns == 0) ? hreq : '0;
      e_l = (ns == 0) ? lreq : '0;
      e_od = (ns == 1);
      e_f = trip | (e_f & ~clr);
      m_st = ns;
      m_sync = {m_sync[0], pin};
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "hi_gate", hgate, e_h);
    chk(tag, "lo_gate", lgate, e_l);
    chk(tag, "od_en", {{(LEGS-1){1'b0}}, od}, {{(LEGS-1){1'b0}}, e_od});
    chk(tag, "fault", {{(LEGS-1){1'b0}}, flt}, {{(LEGS-1){1'b0}}, e_f});
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    @(negedge clk);
    // R1: reset state, gates off while line low
    hreq = 3'b101; lreq = 3'b010;
    steps(3, "R1");
    rst = 1'b0;
    steps(4, "R1");
    // R7: line rises, reaches decisions after two stages
    pin = 1'b1;
    steps(2, "R7");
    // R10: normal running
    steps(3, "R10");
    hreq = 3'b011; lreq = 3'b100; step("R10");
    hreq = 3'b110; lreq = 3'b001; step("R10");
    // R2 R3: trip with line still high
    trip = 1'b1; step("R2");
    if (hgate !== '0 || lgate !== '0) begin
      fails++; $display("FAIL R2 gates actual=%b/%b expected=000/000", hgate, lgate);
    end
    checks++;
    step("R3");
    trip = 1'b0;
    steps(4, "R4");          // R4: held while line high
    pin = 1'b0;
    steps(2, "R5");          // R5: release after sync
    steps(3, "R6");          // R6: still off while low
    pin = 1'b1;
    steps(4, "R6");
    // R4: trip still asserted while line low
    trip = 1'b1; step("R4");
    pin = 1'b0; steps(5, "R4");
    trip = 1'b0; steps(2, "R5");
    pin = 1'b1; steps(4, "R6");
    // R8: external low during running
    pin = 1'b0; steps(4, "R8");
    pin = 1'b1; steps(4, "R8");
    // R9: clear, and clear coinciding with trip
    clr = 1'b1; step("R9"); clr = 1'b0;
    trip = 1'b1; clr = 1'b1; step("R9");
    trip = 1'b0; clr = 1'b0; step("R9");
    clr = 1'b1; step("R9"); clr = 1'b0;
    pin = 1'b0; steps(3, "R9");
    pin = 1'b1; steps(4, "R9");

    // constrained random traffic
    s = $urandom(32'd2718);
    for (int i = 0; i < 4000; i++) begin
      hreq = $urandom; lreq = $urandom;
      trip = ($urandom_range(0, 29) == 0);
      clr  = ($urandom_range(0, 9) == 0);
      if (od) pin = ($urandom_range(0, 3) != 0) ? pin & ($urandom_range(0, 2) != 0) : pin;
      else if ($urandom_range(0, 4) == 0) pin = ~pin;
      else if ($urandom_range(0, 1) == 0) pin = 1'b1;
      if ($urandom_range(0, 999) == 0) rst = 1'b1; else rst = 1'b0;
      step("R10");
    end
    rst = 1'b0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule